// File: doc/BRIEF.md
# Dual Chaotic Map Fixed-Point Iterator

This block is a synchronous entropy source. It runs two one-dimensional chaotic recurrences side by side, a quadratic (logistic) map and a piecewise-linear (tent) map. Both work in unsigned fixed-point fractional arithmetic, so the trajectories are fully deterministic and a software model can reproduce them bit for bit. One shared enable tick advances both maps by exactly one iteration. A valid strobe marks each new pair of state words. A downstream post-processor (bit conversion, mixing, hashing) consumes these words.

States are 16-bit words with 15 fractional bits. The logistic gain and the tent slope are 16-bit words with 2 integer bits and 14 fractional bits. Every product is truncated back to 15 fractional bits. A result that reaches 1.0 or more is clamped to the largest value below 1.0. A synchronous load port replaces both seeds and both parameters in one cycle.

Top module: `chaos_pair_iter`

## Requirements
- R1: After reset both states hold 19988 (0.61), the logistic gain holds 63897 (3.9 in 2.14 format), the tent slope holds 32604 (1.99 in 2.14 format), and outValid is 0.
- R2: When loadEn is high at a clock edge, both states and both parameters take the seed and parameter inputs at that edge and no valid strobe follows. Load wins over a tick in the same cycle.
- R3: On a step, the complement c is (0 − x) modulo 2^15, that is, 1 − x taken within the 15 fractional bits, so x = 0 gives c = 0. The logistic state becomes floor(floor(x·c / 2^15) · r / 2^14), after the clamp of R5.
- R4: On a step, the tent map uses c when fractional bit 14 of x (weight 0.5) is set and uses x itself when it is clear. The new state is floor(operand · a / 2^14), after the clamp of R5.
- R5: Any map result of 32768 or more (≥ 1.0) is stored as 32767.
- R6: outValid is high for exactly one cycle in the cycle after each edge that sees iterTick high and loadEn low. It is low at all other times.
- R7: Both maps advance on the same tick. With neither tick nor load, both states hold their values.
- R8: After any step, bit 15 (the integer bit) of both states is 0, even when a seed of 1.0 or more was loaded.
- R9: Loaded parameters stay in force for every later step until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| iterTick | input | 1 | Advance both maps by one iteration |
| loadEn | input | 1 | Replace seeds and parameters this cycle |
| seedLog | input | 16 | Logistic seed, 1.15 unsigned |
| seedTent | input | 16 | Tent seed, 1.15 unsigned |
| gainIn | input | 16 | Logistic gain r, 2.14 unsigned |
| slopeIn | input | 16 | Tent slope a, 2.14 unsigned |
| logState | output | 16 | Current logistic state |
| tentState | output | 16 | Current tent state |
| outValid | output | 1 | One-cycle strobe after each iteration |

## Verification
Several properties are checked on every cycle by the assertions: states hold when idle, a load is captured exactly, a valid strobe is traced back to a tick without a load, both states stay below 1.0 after a step, and zero is a fixed point of both maps. The exact arithmetic cannot be shown by a property. This covers the truncation points, the tent branch taken at exactly one half, the clamp at 1.0, and parameters carried across many steps. Only the bench's behavioural reference, run over default, gapped, loaded and boundary seeds, can show those.

// File: rtl/chaos_iter_pkg.sv
package chaos_iter_pkg;

  localparam int STATE_W   = 16;
  localparam int FRAC_W    = 15;
  localparam int PARAM_W   = 16;
  localparam int PARAM_FRAC = 14;

  localparam logic [STATE_W-1:0] DEF_SEED  = 16'd19988;
  localparam logic [PARAM_W-1:0] DEF_GAIN  = 16'd63897;
  localparam logic [PARAM_W-1:0] DEF_SLOPE = 16'd32604;

  typedef struct packed {
    logic doLoad;
    logic doStep;
  } ctrl_strobe_t;

endpackage

// File: rtl/chaos_logistic_step.sv
module chaos_logistic_step #(
  parameter int STATE_W    = 16,
  parameter int FRAC_W     = 15,
  parameter int PARAM_W    = 16,
  parameter int PARAM_FRAC = 14
) (
  input  logic [STATE_W-1:0] curX,
  input  logic [PARAM_W-1:0] gain,
  output logic [STATE_W-1:0] nextX
);
  localparam int QUAD_W  = 2 * STATE_W;
  localparam int TRUNC_W = QUAD_W - FRAC_W;
  localparam int SCALE_W = TRUNC_W + PARAM_W;
  localparam int SHIFT_W = SCALE_W - PARAM_FRAC;
  localparam logic [STATE_W-1:0] SAT_VAL = STATE_W'((2 ** FRAC_W) - 1);

  logic [FRAC_W-1:0]  complement;
  logic [QUAD_W-1:0]  quad;
  logic [TRUNC_W-1:0] quadTrunc;
  logic [SCALE_W-1:0] scaled;
  logic [SHIFT_W-1:0] shifted;
  logic               overRange;

  // 1 - x kept inside the fractional field
  assign complement = FRAC_W'(0) - curX[FRAC_W-1:0];
  assign quad       = {{STATE_W{1'b0}}, curX} * {{(QUAD_W-FRAC_W){1'b0}}, complement};
  assign quadTrunc  = quad[QUAD_W-1:FRAC_W];
  assign scaled     = {{PARAM_W{1'b0}}, quadTrunc} * {{TRUNC_W{1'b0}}, gain};
  assign shifted    = scaled[SCALE_W-1:PARAM_FRAC];
  assign overRange  = |shifted[SHIFT_W-1:FRAC_W];
  assign nextX      = overRange ? SAT_VAL
                                : {{(STATE_W-FRAC_W){1'b0}}, shifted[FRAC_W-1:0]};

endmodule

// File: rtl/chaos_tent_step.sv
module chaos_tent_step #(
  parameter int STATE_W    = 16,
  parameter int FRAC_W     = 15,
  parameter int PARAM_W    = 16,
  parameter int PARAM_FRAC = 14
) (
  input  logic [STATE_W-1:0] curX,
  input  logic [PARAM_W-1:0] slope,
  output logic [STATE_W-1:0] nextX
);
  localparam int SCALE_W = STATE_W + PARAM_W;
  localparam int SHIFT_W = SCALE_W - PARAM_FRAC;
  localparam logic [STATE_W-1:0] SAT_VAL = STATE_W'((2 ** FRAC_W) - 1);

  logic [FRAC_W-1:0]  complement;
  logic               upperHalf;
  logic [STATE_W-1:0] operand;
  logic [SCALE_W-1:0] scaled;
  logic [SHIFT_W-1:0] shifted;
  logic               overRange;

  assign complement = FRAC_W'(0) - curX[FRAC_W-1:0];
  // weight-one-half bit alone picks the branch
  assign upperHalf  = curX[FRAC_W-1];
  assign operand    = upperHalf ? {{(STATE_W-FRAC_W){1'b0}}, complement} : curX;
  assign scaled     = {{PARAM_W{1'b0}}, operand} * {{STATE_W{1'b0}}, slope};
  assign shifted    = scaled[SCALE_W-1:PARAM_FRAC];
  assign overRange  = |shifted[SHIFT_W-1:FRAC_W];
  assign nextX      = overRange ? SAT_VAL
                                : {{(STATE_W-FRAC_W){1'b0}}, shifted[FRAC_W-1:0]};

endmodule

// File: rtl/chaos_iter_ctrl.sv
module chaos_iter_ctrl
  import chaos_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         iterTick,
  input  logic         loadEn,
  output ctrl_strobe_t strobes,
  output logic         validOut
);
  logic validQ;

  // load has priority; a tick during a load is dropped
  assign strobes.doLoad = loadEn;
  assign strobes.doStep = iterTick & ~loadEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobes.doStep;
  end

  assign validOut = validQ;

  AST_VALID_TRACES_TICK: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ($past(iterTick) && !$past(loadEn))); // R6

  AST_NO_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> !validOut); // R2

endmodule

// File: rtl/chaos_iter_datapath.sv
module chaos_iter_datapath
  import chaos_iter_pkg::*;
#(
  parameter int STATE_W    = chaos_iter_pkg::STATE_W,
  parameter int FRAC_W     = chaos_iter_pkg::FRAC_W,
  parameter int PARAM_W    = chaos_iter_pkg::PARAM_W,
  parameter int PARAM_FRAC = chaos_iter_pkg::PARAM_FRAC,
  parameter logic [STATE_W-1:0] RST_SEED  = chaos_iter_pkg::DEF_SEED,
  parameter logic [PARAM_W-1:0] RST_GAIN  = chaos_iter_pkg::DEF_GAIN,
  parameter logic [PARAM_W-1:0] RST_SLOPE = chaos_iter_pkg::DEF_SLOPE
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [STATE_W-1:0] seedLog,
  input  logic [STATE_W-1:0] seedTent,
  input  logic [PARAM_W-1:0] gainIn,
  input  logic [PARAM_W-1:0] slopeIn,
  output logic [STATE_W-1:0] logState,
  output logic [STATE_W-1:0] tentState
);
  logic [STATE_W-1:0] logQ, tentQ, logNext, tentNext;
  logic [PARAM_W-1:0] gainQ, slopeQ;

  chaos_logistic_step #(
    .STATE_W(STATE_W), .FRAC_W(FRAC_W), .PARAM_W(PARAM_W), .PARAM_FRAC(PARAM_FRAC)
  ) uLogistic (
    .curX(logQ), .gain(gainQ), .nextX(logNext)
  );

  chaos_tent_step #(
    .STATE_W(STATE_W), .FRAC_W(FRAC_W), .PARAM_W(PARAM_W), .PARAM_FRAC(PARAM_FRAC)
  ) uTent (
    .curX(tentQ), .slope(slopeQ), .nextX(tentNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logQ   <= RST_SEED;
      tentQ  <= RST_SEED;
      gainQ  <= RST_GAIN;
      slopeQ <= RST_SLOPE;
    end else if (strobes.doLoad) begin
      logQ   <= seedLog;
      tentQ  <= seedTent;
      gainQ  <= gainIn;
      slopeQ <= slopeIn;
    end else if (strobes.doStep) begin
      logQ   <= logNext;
      tentQ  <= tentNext;
    end
  end

  assign logState  = logQ;
  assign tentState = tentQ;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLoad |=> (logQ == $past(seedLog)) && (tentQ == $past(seedTent))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLoad && !strobes.doStep) |=> ($stable(logQ) && $stable(tentQ))); // R7

  AST_BELOW_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doStep |=> (!logQ[STATE_W-1] && !tentQ[STATE_W-1])); // R8

  AST_LOG_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStep && logQ == '0) |=> (logQ == '0)); // R3

  AST_TENT_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doStep && tentQ == '0) |=> (tentQ == '0)); // R4

endmodule

// File: rtl/chaos_pair_iter.sv
module chaos_pair_iter
  import chaos_iter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iterTick,
  input  logic        loadEn,
  input  logic [15:0] seedLog,
  input  logic [15:0] seedTent,
  input  logic [15:0] gainIn,
  input  logic [15:0] slopeIn,
  output logic [15:0] logState,
  output logic [15:0] tentState,
  output logic        outValid
);
  ctrl_strobe_t strobes;

  chaos_iter_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .iterTick(iterTick), .loadEn(loadEn),
    .strobes(strobes), .validOut(outValid)
  );

  chaos_iter_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .seedLog(seedLog), .seedTent(seedTent), .gainIn(gainIn), .slopeIn(slopeIn),
    .logState(logState), .tentState(tentState)
  );

endmodule

// File: tb/chaos_pair_iter_test.sv
`timescale 1ns/1ps
module chaos_pair_iter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic iterTick = 1'b0, loadEn = 1'b0;
  logic [15:0] seedLog = '0, seedTent = '0, gainIn = '0, slopeIn = '0;
  logic [15:0] logState, tentState;
  logic outValid;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chaos_pair_iter uut (
    .clk(clk), .rstN(rstN), .iterTick(iterTick), .loadEn(loadEn),
    .seedLog(seedLog), .seedTent(seedTent), .gainIn(gainIn), .slopeIn(slopeIn),
    .logState(logState), .tentState(tentState), .outValid(outValid)
  );

  function automatic longint clampOne(longint v);
    return (v >= 32768) ? 32767 : v;
  endfunction

  function automatic longint refLog(longint x, longint r);
    longint c = (32768 - (x % 32768)) % 32768;
    longint t = (x * c) / 32768;
    return clampOne((t * r) / 16384);
  endfunction

  function automatic longint refTent(longint x, longint a);
    longint c = (32768 - (x % 32768)) % 32768;
    longint op = ((x / 16384) % 2 == 1) ? c : x;
    return clampOne((op * a) / 16384);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, updated from the same sampled inputs
  longint mLog, mTent, mGain, mSlope;
  bit mValid;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLog <= 19988; mTent <= 19988; mGain <= 63897; mSlope <= 32604; mValid <= 0;
    end else begin
      mValid <= iterTick && !loadEn;
      if (loadEn) begin
        mLog <= seedLog; mTent <= seedTent; mGain <= gainIn; mSlope <= slopeIn;
      end else if (iterTick) begin
        mLog <= refLog(mLog, mGain); mTent <= refTent(mTent, mSlope);
      end
    end
  end

  always @(negedge clk) if (rstN && !done) begin
    chk(logState == mLog, "R3 R7 logistic vs model", logState, mLog);
    chk(tentState == mTent, "R4 R7 tent vs model", tentState, mTent);
    chk(outValid == mValid, "R6 valid vs model", outValid, mValid);
    if (outValid) chk(!logState[15] && !tentState[15], "R8 integer bit clear",
                      {logState[15], tentState[15]}, 0);
  end

  task automatic stepOnce;
    iterTick = 1; @(negedge clk); iterTick = 0;
  endtask

  task automatic loadAll(input int ls, input int ts, input int r, input int a);
    loadEn = 1; seedLog = 16'(ls); seedTent = 16'(ts); gainIn = 16'(r); slopeIn = 16'(a);
    @(negedge clk); loadEn = 0;
  endtask

  task automatic finishRun;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #100000;
    chk(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(logState == 19988, "R1 logistic seed", logState, 19988);
    chk(tentState == 19988, "R1 tent seed", tentState, 19988);
    chk(outValid == 0, "R1 valid low", outValid, 0);

    // R1 default parameters in the first step
    stepOnce();
    chk(logState == refLog(19988, 63897), "R1 default gain", logState, refLog(19988, 63897));
    chk(tentState == refTent(19988, 32604), "R1 default slope", tentState, refTent(19988, 32604));
    chk(outValid == 1, "R6 valid after tick", outValid, 1);
    @(negedge clk);
    chk(outValid == 0, "R6 valid single cycle", outValid, 0);

    // back-to-back ticks
    iterTick = 1; repeat (40) @(negedge clk); iterTick = 0;

    // gapped ticks, states hold between
    for (int i = 0; i < 10; i++) begin
      logic [15:0] hl, ht;
      stepOnce();
      hl = logState; ht = tentState;
      repeat (2) @(negedge clk);
      chk(logState == hl && tentState == ht, "R7 hold without tick", logState, hl);
    end

    // R2 load, zero fixed points
    loadAll(0, 0, 63897, 32604);
    chk(logState == 0 && tentState == 0, "R2 load seeds", logState, 0);
    chk(outValid == 0, "R2 no valid on load", outValid, 0);
    stepOnce();
    chk(logState == 0, "R3 zero stays zero", logState, 0);
    chk(tentState == 0, "R4 zero stays zero", tentState, 0);

    // half point: logistic just under one, tent clamped
    loadAll(16384, 16384, 65535, 32768);
    stepOnce();
    chk(logState == 32767, "R3 half with max gain", logState, 32767);
    chk(tentState == 32767, "R5 tent clamp at one", tentState, 32767);

    // tent lower branch just below half
    loadAll(16383, 16383, 65535, 32768);
    stepOnce();
    chk(tentState == 32766, "R4 lower branch", tentState, 32766);

    // tent upper branch uses complement
    loadAll(8192, 24576, 65535, 32768);
    stepOnce();
    chk(tentState == 16384, "R4 upper branch", tentState, 16384);
    chk(logState == refLog(8192, 65535), "R3 quarter point", logState, refLog(8192, 65535));

    // seed above one is pulled below one
    loadAll(40000, 40000, 65535, 32768);
    stepOnce();
    chk(!logState[15] && !tentState[15], "R8 oversize seed", {logState[15], tentState[15]}, 0);
    chk(tentState == refTent(40000, 32768), "R5 oversize tent", tentState, refTent(40000, 32768));

    // load and tick together: load wins
    loadEn = 1; iterTick = 1;
    seedLog = 16'd1000; seedTent = 16'd2000; gainIn = 16'd57344; slopeIn = 16'd24576;
    @(negedge clk); loadEn = 0; iterTick = 0;
    chk(logState == 1000 && tentState == 2000, "R2 load beats tick", logState, 1000);
    chk(outValid == 0, "R2 load beats tick valid", outValid, 0);

    // R9 loaded parameters persist
    begin
      longint el = 1000, et = 2000;
      for (int i = 0; i < 20; i++) begin
        el = refLog(el, 57344); et = refTent(et, 24576);
        stepOnce();
      end
      chk(logState == el, "R9 gain persists", logState, el);
      chk(tentState == et, "R9 slope persists", tentState, et);
    end

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule